// File: doc/BRIEF.md
# Masked Key Change Interrupt

This block watches a small input port and raises a single shared interrupt factor flag when any input that is enabled in its mask register goes high. Each input first passes through a two-flop synchroniser. Detection works on the gated level of each input, which is the synchronised value ANDed with its enable bit. A flag set happens whenever a gated level goes from low to high.

Because of this scheme, rewriting the mask has a side effect. If an enable is cleared and then set again while its input is held high, the flag sets a second time. If the mask is left alone, an input that stays high sets the flag only once.

Software reaches the block through a small register bus with an address, write and read strobes, and combinational read data. It can read the synchronised inputs, read and write the mask, and read the flag. Reading the flag also clears it. The interrupt request output follows the flag.

Top module: `kport_change_irq`

## Requirements
- R1: After reset the mask register reads 0, the flag reads 0 and `irq_o` is low.
- R2: An input rising while its enable bit is 1 sets the flag. `irq_o` goes high after the third rising clock edge that follows the input change.
- R3: An input rising while its enable bit is 0 never sets the flag.
- R4: An enabled input that stays high without any mask rewrite sets the flag only once. After the flag is read and cleared, it stays clear.
- R5: Writing an enable bit to 1 while its synchronised input is high sets the flag on the second clock edge after the write strobe. This includes the case where the bit was just cleared by the previous write. Enabling an input that is low does not set the flag.
- R6: A read strobe at address 2 returns the flag in bit 0 (upper bits 0). The flag then clears on that clock edge.
- R7: When a set event and a flag read occur on the same clock edge, the flag ends up set.
- R8: A read at address 0 returns the input port through the synchroniser, two clock edges after the input change.
- R9: Address 1 reads back the mask register, and writes to it take effect on the next edge. Writes to addresses 0 and 2 change neither the mask nor the flag.
- R10: `irq_o` is high exactly while the flag is set.
- R11: An enabled input falling from high to low does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| kin_i | input | 4 | Asynchronous input port |
| addr_i | input | 2 | Register address: 0 input data, 1 mask, 2 flag |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a read at address 2 clears the flag |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets three situations. The first is mask rewrites on an input that is held high, both back-to-back clear/set writes and a fresh enable. A design that detects raw input edges would miss the second set, and one that gates too late would set the flag on the wrong cycle. The second is a read that coincides with a set event. A design that gives the clear priority would lose that interrupt. The third covers inputs that are held high, falling, or masked; a level-sensitive or ungated design would raise spurious requests for these. The bench also checks synchroniser latency on data reads and confirms that writes to read-only addresses are ignored.

// File: rtl/kci_pkg.sv
package kci_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/kci_sync.sv
module kci_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kci_detect.sv
module kci_detect #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [N-1:0] gated, prev_q;
  logic         set_ev, flag_q;

  // gating before the edge compare makes a mask 0->1 on a high input look like a rise
  assign gated  = lvl_i & en_i;
  assign set_ev = |(gated & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= gated;
      if (set_ev)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/kci_regs.sv
module kci_regs
  import kci_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      lvl_i,
  input  logic              flag_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      rdata_o,
  output logic              clr_o
);
  reg_sel_e     sel;
  logic [N-1:0] mask_q;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mask_q <= '0;
    else if (wr_i && sel == SEL_MASK) mask_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_DATA: rdata_o = lvl_i;
      SEL_MASK: rdata_o = mask_q;
      SEL_FLAG: rdata_o[0] = flag_i;
      default:  rdata_o = '0;
    endcase
  end

  assign clr_o  = rd_i && sel == SEL_FLAG;
  assign mask_o = mask_q;
endmodule

// File: rtl/kport_change_irq.sv
module kport_change_irq
  import kci_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   kin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [N_IN-1:0]   wdata_i,
  output logic [N_IN-1:0]   rdata_o,
  output logic              irq_o
);
  logic [N_IN-1:0] lvl, mask_q;
  logic            flag_q, clr;

  kci_sync #(.N(N_IN), .STAGES(SYNC_STGS)) u_sync (
    .clk_i, .rst_ni, .d_i(kin_i), .q_o(lvl)
  );

  kci_detect #(.N(N_IN)) u_det (
    .clk_i, .rst_ni, .lvl_i(lvl), .en_i(mask_q), .clr_i(clr), .flag_o(flag_q)
  );

  kci_regs #(.N(N_IN)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .lvl_i(lvl), .flag_i(flag_q), .mask_o(mask_q), .rdata_o, .clr_o(clr)
  );

  assign irq_o = flag_q;
endmodule

// File: rtl/kci_checker.sv
module kci_checker
  import kci_pkg::*;
#(
  parameter int N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      rdata_o,
  input logic              irq_o,
  input logic [N-1:0]      lvl,
  input logic [N-1:0]      mask_q
);
  // R2 R3: a new request needs an enabled, high synchronised input
  p_rise_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(lvl & mask_q)));

  // R6: the request only drops after a flag read
  p_clear_by_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(rd_i && addr_i == ADDR_W'(SEL_FLAG)));

  // R6 R10: flag read returns the request level
  p_flag_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(SEL_FLAG)) |-> (rdata_o == N'(irq_o)));

  p_mask_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && addr_i == ADDR_W'(SEL_MASK)) |-> mask_q == $past(wdata_i));

  p_mask_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i && addr_i == ADDR_W'(SEL_MASK)) |-> $stable(mask_q));
endmodule

bind kport_change_irq kci_checker #(.N(N_IN)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .irq_o,
  .lvl(lvl), .mask_q(mask_q)
);

// File: tb/kport_change_irq_bench.sv
module kport_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] kin = '0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, chk_req = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       irq;

  typedef struct {
    bit         is_irq;
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  kport_change_irq u_kport_change_irq (
    .clk_i(clk), .rst_ni(rst_n), .kin_i(kin), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [3:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [3:0] e, input string tag);
    exp_q.push_back('{1'b0, e, tag});
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    exp_q.push_back('{1'b1, {3'b000, e}, tag});
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
  endtask

  // monitor: pops one expected item per probed cycle
  initial forever begin
    @(negedge clk);
    #3;
    if (rd || chk_req) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: no expected item, actual %h expected none", rdata);
      end else begin
        item_t it;
        logic [3:0] act;
        it  = exp_q.pop_front();
        act = it.is_irq ? {3'b000, irq} : rdata;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1
    rd_reg(2'd1, 4'h0, "R1 mask after reset");
    rd_reg(2'd2, 4'h0, "R1 flag after reset");
    irq_chk(1'b0, "R1 irq after reset");
    // R3 masked rise
    kin = 4'b0001;
    idle(4);
    irq_chk(1'b0, "R3 masked input");
    rd_reg(2'd0, 4'b0001, "R8 data path");
    kin = 4'b0000;
    idle(3);
    // R9
    wr_reg(2'd1, 4'b0110);
    rd_reg(2'd1, 4'b0110, "R9 mask readback");
    wr_reg(2'd0, 4'hF);
    wr_reg(2'd2, 4'hF);
    rd_reg(2'd1, 4'b0110, "R9 mask after ro writes");
    irq_chk(1'b0, "R9 flag after ro write");
    // R2 latency
    kin = 4'b0010;
    idle(2);
    irq_chk(1'b0, "R2 not before third edge");
    irq_chk(1'b1, "R2 set after third edge");
    irq_chk(1'b1, "R10 irq follows flag");
    rd_reg(2'd2, 4'h1, "R6 flag read");
    irq_chk(1'b0, "R6 cleared by read");
    // R4 held high
    idle(5);
    irq_chk(1'b0, "R4 held high no re-set");
    // R11 fall
    kin = 4'b0000;
    idle(4);
    irq_chk(1'b0, "R11 fall ignored");
    // R8 latency, multi-bit
    kin = 4'b1010;
    idle(1);
    rd_reg(2'd0, 4'b0000, "R8 one edge only");
    rd_reg(2'd0, 4'b1010, "R8 after two edges");
    rd_reg(2'd2, 4'h1, "R2 enabled bit1 rise");
    // R5 clear then set while high
    wr_reg(2'd1, 4'b0100);
    wr_reg(2'd1, 4'b0110);
    irq_chk(1'b0, "R5 one edge after write");
    irq_chk(1'b1, "R5 re-enable sets");
    rd_reg(2'd2, 4'h1, "R5 flag read");
    wr_reg(2'd1, 4'b1110);
    irq_chk(1'b0, "R5 fresh enable one edge");
    irq_chk(1'b1, "R5 fresh enable high sets");
    rd_reg(2'd2, 4'h1, "R5 flag read 2");
    wr_reg(2'd1, 4'b1111);
    idle(2);
    irq_chk(1'b0, "R5 enable low input");
    // R7 set vs read
    kin = 4'b1011;
    idle(2);
    rd_reg(2'd2, 4'h0, "R7 read in set cycle");
    irq_chk(1'b1, "R7 set wins");
    rd_reg(2'd2, 4'h1, "R7 flag kept");
    irq_chk(1'b0, "R6 cleared again");
    idle(2);
    wait (exp_q.size() == 0);
    idle(1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule